// File: doc/BRIEF.md
# Sliced-Data Readback Latch

This block sits between a line-rate data slicer and a slow host register bus. At the end of each video line the slicer gives one strobe, a flag that says whether the line carried data, and the decoded payload word. The latch copies one payload into a holding register and raises an available flag. It then freezes that copy, so the host can read it over a bus that is much slower than the line rate.

The host re-arms the latch with a write-only clear strobe. The clear drops the available flag. The next suitable line is then captured.

A content-based mode is on after reset. In this mode the latch reports only lines whose payload differs from the last value reported. It also reports a return of data after a gap. When data stops for four lines in a row, it reports a loss with a zero payload. Each report also sets a sticky interrupt request. The interrupt stays set until the next clear and is gated by an interrupt-enable bit.

Top module: `slice_readback`

## Requirements
- R1: After synchronous reset, `avail`=0, `heldData`=0, `irq`=0 and `cbMode`=1, and the latch is armed. The interrupt enable resets to 0.
- R2: While armed (`avail`=0, no clear in the same cycle), a line with `lineValid`=1 that qualifies for capture is copied to `heldData`. `avail` is 1 in the cycle after the strobe.
- R3: While `avail`=1, no line event changes `heldData` or `avail`.
- R4: A `hostClear` pulse makes `avail`=0 and clears the pending interrupt from the next cycle. A line strobe in the same cycle as the clear is not captured.
- R5: With `cbMode`=0, every armed valid line is captured, even when its payload equals the held one.
- R6: With `cbMode`=1, an armed valid line whose payload equals the last reported payload is not captured, and `avail` stays 0.
- R7: With `cbMode`=1 and a last report that carried data, the fourth consecutive empty line reports a loss while armed: `avail`=1 and `heldData`=0. One to three empty lines report nothing.
- R8: With `cbMode`=1, the first valid line after a reported loss is captured whatever its value, zero included.
- R9: A capture or loss report sets a pending interrupt that stays until `hostClear`. `irq` equals pending AND interrupt enable.
- R10: A `cfgWe` pulse loads `cfgCbIn` into `cbMode` and `cfgIrqEnIn` into the interrupt enable. The new values take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lineStrobe | input | 1 | One-cycle pulse at the end of each decoded line |
| lineValid | input | 1 | The line carried data (qualified by `lineStrobe`) |
| lineData | input | DATA_W | Decoded payload of the line |
| hostClear | input | 1 | Host write of 1 to the clear bit (self-clearing pulse) |
| cfgWe | input | 1 | Configuration write strobe |
| cfgCbIn | input | 1 | Content-based mode value to load |
| cfgIrqEnIn | input | 1 | Interrupt enable value to load |
| avail | output | 1 | Held payload is valid |
| heldData | output | DATA_W | Latched payload |
| irq | output | 1 | Sticky, masked interrupt request |
| cbMode | output | 1 | Current content-based mode bit |

## Verification
The bench builds the block with a 4-bit payload and the default four-line loss window. With a 4-bit payload, repeated and changed values come up often, so equal-payload suppression in content-based mode shows up on many lines. The two-bit empty-line counter reaches saturation within a few lines. A long pseudo-random line sequence mixes empty runs, clears that coincide with strobes, and mode changes. A bench model checks every cycle of that sequence, in addition to the directed corner cases.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef struct packed {
    logic capture;  // load payload into held and reference copies
    logic lossZero; // zero held and reference copies
  } ctlStrb_t;
endpackage

// File: rtl/rb_ctrl.sv
module rb_ctrl #(
  parameter int LOSS_LINES = 4,
  localparam int CNT_W = $clog2(LOSS_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lineStrobe,
  input  logic             lineValid,
  input  logic             hostClear,
  input  logic             cfgWe,
  input  logic             cfgCbIn,
  input  logic             cfgIrqEnIn,
  input  logic             dataDiffers,
  output rb_pkg::ctlStrb_t strb,
  output logic             avail,
  output logic             irq,
  output logic             cbMode
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOSS_LINES - 1);

  logic             availQ;
  logic             repHave;
  logic             irqPend;
  logic             irqEn;
  logic             cbQ;
  logic [CNT_W-1:0] emptyCnt;
  logic             armed;
  logic             takeLine;
  logic             takeLoss;

  always_comb begin
    armed    = !availQ && !hostClear;
    takeLine = lineStrobe && lineValid && armed &&
               (!cbQ || !repHave || dataDiffers);
    takeLoss = lineStrobe && !lineValid && armed && cbQ && repHave &&
               (emptyCnt == CNT_LAST);
    strb.capture  = takeLine;
    strb.lossZero = takeLoss;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      availQ   <= 1'b0;
      repHave  <= 1'b0;
      irqPend  <= 1'b0;
      irqEn    <= 1'b0;
      cbQ      <= 1'b1;
      emptyCnt <= '0;
    end else begin
      if (cfgWe) begin
        cbQ   <= cfgCbIn;
        irqEn <= cfgIrqEnIn;
      end
      if (lineStrobe) begin
        if (lineValid)
          emptyCnt <= '0;
        else if (emptyCnt != CNT_LAST)
          emptyCnt <= emptyCnt + 1'b1;
      end
      if (takeLine)
        repHave <= 1'b1;
      else if (takeLoss)
        repHave <= 1'b0;
      if (hostClear) begin
        availQ  <= 1'b0;
        irqPend <= 1'b0;
      end else if (takeLine || takeLoss) begin
        availQ  <= 1'b1;
        irqPend <= 1'b1;
      end
    end
  end

  assign avail  = availQ;
  assign irq    = irqPend && irqEn;
  assign cbMode = cbQ;
endmodule

// File: rtl/rb_datapath.sv
module rb_datapath #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  rb_pkg::ctlStrb_t  strb,
  input  logic [DATA_W-1:0] lineData,
  output logic [DATA_W-1:0] heldData,
  output logic              dataDiffers
);
  logic [DATA_W-1:0] heldQ;
  logic [DATA_W-1:0] refQ; // last reported payload

  always_ff @(posedge clk) begin
    if (rst) begin
      heldQ <= '0;
      refQ  <= '0;
    end else if (strb.capture) begin
      heldQ <= lineData;
      refQ  <= lineData;
    end else if (strb.lossZero) begin
      heldQ <= '0;
      refQ  <= '0;
    end
  end

  assign heldData    = heldQ;
  assign dataDiffers = (lineData != refQ);
endmodule

// File: rtl/slice_readback.sv
module slice_readback #(
  parameter int DATA_W     = 16,
  parameter int LOSS_LINES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lineStrobe,
  input  logic              lineValid,
  input  logic [DATA_W-1:0] lineData,
  input  logic              hostClear,
  input  logic              cfgWe,
  input  logic              cfgCbIn,
  input  logic              cfgIrqEnIn,
  output logic              avail,
  output logic [DATA_W-1:0] heldData,
  output logic              irq,
  output logic              cbMode
);
  rb_pkg::ctlStrb_t strb;
  logic             dataDiffers;

  rb_ctrl #(.LOSS_LINES(LOSS_LINES)) uCtrl (
    .clk(clk), .rst(rst), .lineStrobe(lineStrobe), .lineValid(lineValid),
    .hostClear(hostClear), .cfgWe(cfgWe), .cfgCbIn(cfgCbIn),
    .cfgIrqEnIn(cfgIrqEnIn), .dataDiffers(dataDiffers), .strb(strb),
    .avail(avail), .irq(irq), .cbMode(cbMode)
  );

  rb_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rst(rst), .strb(strb), .lineData(lineData),
    .heldData(heldData), .dataDiffers(dataDiffers)
  );
endmodule

// File: rtl/slice_readback_chk.sv
module slice_readback_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              lineStrobe,
  input logic              lineValid,
  input logic [DATA_W-1:0] lineData,
  input logic              hostClear,
  input logic              avail,
  input logic [DATA_W-1:0] heldData,
  input logic              irq,
  input logic              cbMode
);
  a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
    (avail && !hostClear) |=> (avail && $stable(heldData)));

  a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
    hostClear |=> (!avail && !irq));

  a_r5_plain_capture: assert property (@(posedge clk) disable iff (rst)
    (!avail && !hostClear && lineStrobe && lineValid && !cbMode)
      |=> (avail && heldData == $past(lineData)));

  a_r9_irq_implies_avail: assert property (@(posedge clk) disable iff (rst)
    irq |-> avail);

  a_r7_loss_zero: assert property (@(posedge clk) disable iff (rst)
    ($rose(avail) && !$past(lineValid)) |-> (heldData == '0));
endmodule

bind slice_readback slice_readback_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rst(rst), .lineStrobe(lineStrobe), .lineValid(lineValid),
  .lineData(lineData), .hostClear(hostClear), .avail(avail),
  .heldData(heldData), .irq(irq), .cbMode(cbMode)
);

// File: tb/tb_slice_readback.sv
module tb_slice_readback;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lineStrobe = 1'b0, lineValid = 1'b0;
  logic [DW-1:0] lineData = '0;
  logic          hostClear = 1'b0, cfgWe = 1'b0, cfgCbIn = 1'b0, cfgIrqEnIn = 1'b0;
  logic          avail, irq, cbMode;
  logic [DW-1:0] heldData;

  int  nRun = 0, nFail = 0;
  bit  done = 1'b0;

  // bench model state
  bit          mAvail, mHave, mPend, mIrqEn, mCb;
  bit [DW-1:0] mHeld, mRef;
  int          mCnt;

  always #4 clk = ~clk;

  slice_readback #(.DATA_W(DW), .LOSS_LINES(4)) dut (
    .clk(clk), .rst(rst), .lineStrobe(lineStrobe), .lineValid(lineValid),
    .lineData(lineData), .hostClear(hostClear), .cfgWe(cfgWe),
    .cfgCbIn(cfgCbIn), .cfgIrqEnIn(cfgIrqEnIn), .avail(avail),
    .heldData(heldData), .irq(irq), .cbMode(cbMode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mAvail = 0; mHave = 0; mPend = 0; mIrqEn = 0; mCb = 1;
    mHeld = '0; mRef = '0; mCnt = 0;
  endtask

  // one clock: drive at negedge, update model, compare just after posedge
  task automatic cyc(input bit ls, input bit lv, input int ld, input bit clr,
                     input bit we, input bit wcb, input bit wie, input string tag);
    bit armed, cap, los;
    @(negedge clk);
    lineStrobe = ls; lineValid = lv; lineData = DW'(ld);
    hostClear = clr; cfgWe = we; cfgCbIn = wcb; cfgIrqEnIn = wie;
    armed = !mAvail && !clr;
    cap = ls && lv && armed && (!mCb || !mHave || DW'(ld) != mRef);
    los = ls && !lv && armed && mCb && mHave && (mCnt == 3);
    if (ls) mCnt = lv ? 0 : ((mCnt < 3) ? mCnt + 1 : 3);
    if (cap) begin mHeld = DW'(ld); mRef = DW'(ld); mHave = 1; end
    else if (los) begin mHeld = '0; mRef = '0; mHave = 0; end
    if (clr) begin mAvail = 0; mPend = 0; end
    else if (cap || los) begin mAvail = 1; mPend = 1; end
    if (we) begin mCb = wcb; mIrqEn = wie; end
    @(posedge clk);
    #1;
    chk(avail == mAvail, {tag, " avail"}, avail, mAvail);
    chk(heldData == mHeld, {tag, " held"}, heldData, mHeld);
    chk(irq == (mPend && mIrqEn), {tag, " irq"}, irq, mPend && mIrqEn);
    chk(cbMode == mCb, {tag, " cbMode"}, cbMode, mCb);
  endtask

  task automatic line(input bit lv, input int ld, input string tag);
    cyc(1, lv, ld, 0, 0, 0, 0, tag);
  endtask
  task automatic clear(input string tag);
    cyc(0, 0, 0, 1, 0, 0, 0, tag);
  endtask
  task automatic cfg(input bit cb, input bit ie, input string tag);
    cyc(0, 0, 0, 0, 1, cb, ie, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nFail++; nRun++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr = 16'hACE1;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk(avail == 0, "R1 avail", avail, 0);
    chk(heldData == 0, "R1 held", heldData, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(cbMode == 1, "R1 cbMode", cbMode, 1);

    // R10 config load
    cfg(0, 1, "R10");
    chk(cbMode == 0, "R10 cbMode", cbMode, 0);
    // R2 capture, R9 interrupt raised
    line(1, 5, "R2");
    chk(avail && heldData == 5, "R2 capture", heldData, 5);
    chk(irq == 1, "R9 irq set", irq, 1);
    // R3 frozen
    line(1, 9, "R3");
    chk(heldData == 5, "R3 frozen", heldData, 5);
    // R4 clear
    clear("R4");
    chk(avail == 0 && irq == 0, "R4 cleared", avail, 0);
    // R5 same value captured in plain mode
    line(1, 5, "R5");
    chk(avail == 1, "R5 repeat captured", avail, 1);
    clear("R4");
    // R4 clear coinciding with a line
    cyc(1, 1, 7, 1, 0, 0, 0, "R4 same-cycle");
    cyc(0, 0, 0, 0, 0, 0, 0, "R4 idle");
    chk(avail == 0 && heldData == 5, "R4 coincident line dropped", heldData, 5);

    // R6 content mode suppresses equal payload
    cfg(1, 1, "R10");
    line(1, 5, "R6");
    chk(avail == 0, "R6 equal suppressed", avail, 0);
    line(1, 6, "R6");
    chk(avail == 1 && heldData == 6, "R6 change captured", heldData, 6);
    clear("R4");
    // R7 loss after four empty lines
    for (int i = 0; i < 3; i++) line(0, 0, "R7");
    chk(avail == 0, "R7 three empties quiet", avail, 0);
    line(0, 0, "R7");
    chk(avail == 1 && heldData == 0, "R7 loss reported", avail, 1);
    chk(irq == 1, "R9 loss irq", irq, 1);
    clear("R4");
    // R8 return of data, zero value
    line(1, 0, "R8");
    chk(avail == 1 && heldData == 0, "R8 return captured", avail, 1);
    // R9 mask
    cfg(1, 0, "R9");
    chk(irq == 0 && avail == 1, "R9 masked", irq, 0);
    clear("R4");

    // pseudo-random sweep against the model
    for (int n = 0; n < 6000; n++) begin
      bit ls, lv, clr, we;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ls  = lfsr[0] | lfsr[1];
      lv  = lfsr[3:2] != 2'b00;
      clr = lfsr[7:4] == 4'h3;
      we  = lfsr[11:8] == 4'h0;
      cyc(ls, lv, int'(lfsr[13:12]), clr, we, lfsr[14], lfsr[15], "sweep R2 R3 R6 R7 R8");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule